// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits next to a small processor core and chooses which of five interrupt sources to serve. The sources are two external pins, two timer overflow flags, and one serial request formed from a receive line and a transmit line. Software programs an enable register, a priority register, a trigger-mode register for the external pins, and the timer flags. The controller raises one request line toward the core. When the core acknowledges, the controller stores a fixed 16-bit handler address for the winning source.

Nesting has two levels. A handler marked high priority may preempt a low-priority handler that is running. A request at the same level as the running handler waits until the core signals a return from interrupt. An in-service bit for each level records which handlers are active, and each return strobe clears the higher of the two bits that is set.

Top module: `two_level_intc`

## Requirements
- R1: After reset the enable and priority registers read 0x00, the in-service bits are 00, `irq_o` is low and `vec_o` is 0x0000.
- R2: Writes use `wr_addr_i`: 0 writes the enable register, 1 the priority register, 2 the trigger-mode register, 3 the timer flags. In the enable register, bit 7 is the global enable, bit 5 is a stored timer 2 bit, bit 4 is serial, bit 3 is timer 1, bit 2 is external 1, bit 1 is timer 0 and bit 0 is external 0. Bit 6 reads 0.
- R3: While enable bit 7 is 0, `irq_o` stays low whatever the other enable bits and the flags hold.
- R4: In the priority register, bits 3..0 mark timer 1, external 1, timer 0 and external 0 as high priority, in that order from bit 3 down to bit 0. Bits 7..4 read 0.
- R5: On an accepted acknowledge, `vec_o` takes the winner's address from the next cycle: external 0 0x0003, timer 0 0x000B, external 1 0x0013, timer 1 0x001B, serial 0x0023.
- R6: Among pending sources at one level, the order of precedence is external 0, then timer 0, then external 1, then timer 1, then serial.
- R7: A high-priority request is offered while only the low in-service bit is set. While the high in-service bit is set, no request is offered.
- R8: While the low in-service bit is set, low-priority requests are held back.
- R9: In level mode (trigger bit 0), an external pin requests service for as long as it is high, so it requests again after service if it is still high.
- R10: In edge mode (trigger bit 1), a 0-to-1 change seen between two clock samples latches a request. An acknowledge of that source clears the latch, and a pin that stays high raises no new request.
- R11: The serial request is the OR of `ser_rx_i` and `ser_tx_i`. It is never cleared by the controller and is always low priority.
- R12: A pulse on `tmr_ovf_i[k]` or a software write to the timer flags (bit k = timer k) sets the flag, and a set flag raises a request when the source is enabled. An acknowledge of that timer clears its flag.
- R13: `reti_i` clears the high in-service bit if it is set and otherwise the low one. An accepted acknowledge sets the in-service bit of the winner's level. `insvc_o` is {high, low}.
- R14: An acknowledge while `irq_o` is low changes neither `vec_o` nor `insvc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select for the write |
| wr_data_i | input | 8 | Write data |
| ext_i | input | 2 | External interrupt pins |
| tmr_ovf_i | input | 2 | Timer overflow set pulses |
| ser_rx_i | input | 1 | Serial receive request |
| ser_tx_i | input | 1 | Serial transmit request |
| ack_i | input | 1 | Acknowledge from the core |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Request to the core |
| vec_o | output | 16 | Latched handler address |
| en_reg_o | output | 8 | Enable register readback |
| pri_reg_o | output | 8 | Priority register readback |
| tmr_flag_o | output | 2 | Timer flag readback |
| insvc_o | output | 2 | In-service bits {high, low} |

## Verification
`irq_o` is combinational from registered state and from the live level inputs (external pins in level mode, and the serial lines). It therefore follows such an input in the same cycle, but it reflects a register write, a timer pulse, or an edge-mode pin rise only after one clock edge. `vec_o`, `insvc_o` and `tmr_flag_o` change on the edge that accepts an acknowledge, a return or a write. The bench drives inputs on the falling edge and compares every output with its reference model shortly after that, before the next rising edge. Directed checks are made only after the edge that should have produced the result.

// File: rtl/intc_pkg.sv
package intc_pkg;

   typedef enum logic [1:0] {
      RSEL_ENABLE  = 2'd0,
      RSEL_PRIO    = 2'd1,
      RSEL_TRIGGER = 2'd2,
      RSEL_TFLAG   = 2'd3
   } reg_sel_e;

   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } level_e;

   // handler address of source slot idx
   function automatic int unsigned slot_addr(int unsigned base, int unsigned stride,
                                             int unsigned idx);
      return base + idx * stride;
   endfunction

endpackage

// File: rtl/intc_edge_det.sv
// One external pin: level pass-through or latched rising edge.
module intc_edge_det (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   input  logic edge_mode_i,
   input  logic clr_i,
   output logic req_o
);
   logic prev_q;
   logic latch_q;
   logic latch_d;

   always_comb begin
      latch_d = edge_mode_i & ((pin_i & ~prev_q) | (latch_q & ~clr_i));
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         prev_q  <= pin_i;
         latch_q <= latch_d;
      end
   end

   assign req_o = edge_mode_i ? latch_q : pin_i;
endmodule

// File: rtl/intc_tmr_flags.sv
// Timer overflow flags: hardware set wins over software write and acknowledge clear.
module intc_tmr_flags #(
   parameter int unsigned NUM = 2
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [NUM-1:0] set_i,
   input  logic           wr_i,
   input  logic [NUM-1:0] wr_data_i,
   input  logic [NUM-1:0] clr_i,
   output logic [NUM-1:0] flag_o
);
   logic [NUM-1:0] flag_q;

   generate
      for (genvar k = 0; k < NUM; k++) begin : g_flag
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               flag_q[k] <= 1'b0;
            end else if (set_i[k]) begin
               flag_q[k] <= 1'b1;
            end else if (wr_i) begin
               flag_q[k] <= wr_data_i[k];
            end else if (clr_i[k]) begin
               flag_q[k] <= 1'b0;
            end
         end
      end
   endgenerate

   assign flag_o = flag_q;
endmodule

// File: rtl/intc_pick.sv
// Fixed-order selector: lowest set index wins.
module intc_pick #(
   parameter int unsigned N = 5,
   localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] req_i,
   output logic         found_o,
   output logic [W-1:0] idx_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            found_o = 1'b1;
            idx_o   = W'(i);
         end
      end
   end
endmodule

// File: rtl/intc_nest.sv
// Two in-service bits; return clears the higher one that is set.
module intc_nest
   import intc_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       take_i,
   input  level_e     take_lvl_i,
   input  logic       ret_i,
   output logic [1:0] ins_o
);
   logic [1:0] ins_q;
   logic [1:0] ins_d;

   always_comb begin
      ins_d = ins_q;
      if (ret_i) begin
         if (ins_d[LVL_HIGH]) ins_d[LVL_HIGH] = 1'b0;
         else                 ins_d[LVL_LOW]  = 1'b0;
      end
      if (take_i) ins_d[take_lvl_i] = 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) ins_q <= 2'b00;
      else         ins_q <= ins_d;
   end

   assign ins_o = ins_q;
endmodule

// File: rtl/two_level_intc.sv
module two_level_intc
   import intc_pkg::*;
#(
   parameter int unsigned         NUM_EXT    = 2,
   parameter int unsigned         NUM_TMR    = 2,
   parameter int unsigned         REG_W      = 8,
   parameter int unsigned         VEC_W      = 16,
   parameter int unsigned         VEC_BASE   = 3,
   parameter int unsigned         VEC_STRIDE = 8,
   parameter int unsigned         GLOBAL_BIT = 7,
   parameter logic [REG_W-1:0]    EN_MASK    = 8'hBF,
   localparam int unsigned        SRC_N      = NUM_EXT + NUM_TMR + 1,
   localparam int unsigned        SRC_W      = $clog2(SRC_N),
   localparam int unsigned        PRI_N      = SRC_N - 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_i,
   input  logic [1:0]         wr_addr_i,
   input  logic [REG_W-1:0]   wr_data_i,
   input  logic [NUM_EXT-1:0] ext_i,
   input  logic [NUM_TMR-1:0] tmr_ovf_i,
   input  logic               ser_rx_i,
   input  logic               ser_tx_i,
   input  logic               ack_i,
   input  logic               reti_i,
   output logic               irq_o,
   output logic [VEC_W-1:0]   vec_o,
   output logic [REG_W-1:0]   en_reg_o,
   output logic [REG_W-1:0]   pri_reg_o,
   output logic [NUM_TMR-1:0] tmr_flag_o,
   output logic [1:0]         insvc_o
);
   localparam int unsigned SER_IDX = SRC_N - 1;

   // elaboration checks
   generate
      if (NUM_EXT != NUM_TMR) begin : g_bad_pairs
         $error("external and timer source counts must match");
      end
      if (GLOBAL_BIT >= REG_W || GLOBAL_BIT < SRC_N) begin : g_bad_global
         $error("global enable bit must sit above the source enables");
      end
      if (PRI_N > REG_W || NUM_EXT > REG_W) begin : g_bad_regw
         $error("register width too small");
      end
      if (VEC_W > 32 || VEC_STRIDE == 0) begin : g_bad_vec
         $error("vector geometry out of range");
      end
   endgenerate

   // software registers
   logic [REG_W-1:0]   en_q;
   logic [PRI_N-1:0]   pri_q;
   logic [NUM_EXT-1:0] trig_q;
   logic               wr_flags;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         en_q   <= '0;
         pri_q  <= '0;
         trig_q <= '0;
      end else if (wr_i) begin
         case (reg_sel_e'(wr_addr_i))
            RSEL_ENABLE:  en_q   <= wr_data_i & EN_MASK;
            RSEL_PRIO:    pri_q  <= wr_data_i[PRI_N-1:0];
            RSEL_TRIGGER: trig_q <= wr_data_i[NUM_EXT-1:0];
            default:      ;
         endcase
      end
   end

   assign wr_flags = wr_i & (reg_sel_e'(wr_addr_i) == RSEL_TFLAG);

   // source requests, slot 2k = external k, slot 2k+1 = timer k, last = serial
   logic [SRC_N-1:0]   src_req;
   logic [SRC_N-1:0]   src_clr;
   logic [NUM_TMR-1:0] tmr_clr;
   logic [NUM_TMR-1:0] tmr_flag;

   generate
      for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
         intc_edge_det u_det (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .pin_i       (ext_i[k]),
            .edge_mode_i (trig_q[k]),
            .clr_i       (src_clr[2*k]),
            .req_o       (src_req[2*k])
         );
      end
      for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
         assign tmr_clr[k]       = src_clr[2*k+1];
         assign src_req[2*k+1]   = tmr_flag[k];
      end
   endgenerate

   assign src_req[SER_IDX] = ser_rx_i | ser_tx_i;

   intc_tmr_flags #(.NUM(NUM_TMR)) u_flags (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (tmr_ovf_i),
      .wr_i      (wr_flags),
      .wr_data_i (wr_data_i[NUM_TMR-1:0]),
      .clr_i     (tmr_clr),
      .flag_o    (tmr_flag)
   );

   // gating and level split
   logic             global_en;
   logic [SRC_N-1:0] live;
   logic [SRC_N-1:0] hi_mask;
   logic [SRC_N-1:0] hi_req;
   logic [SRC_N-1:0] lo_req;

   assign global_en = en_q[GLOBAL_BIT];
   assign live      = src_req & en_q[SRC_N-1:0] & {SRC_N{global_en}};
   assign hi_mask   = {1'b0, pri_q};
   assign hi_req    = live & hi_mask;
   assign lo_req    = live & ~hi_mask;

   logic             hi_found, lo_found;
   logic [SRC_W-1:0] hi_idx, lo_idx;

   intc_pick #(.N(SRC_N)) u_pick_hi (
      .req_i   (hi_req),
      .found_o (hi_found),
      .idx_o   (hi_idx)
   );

   intc_pick #(.N(SRC_N)) u_pick_lo (
      .req_i   (lo_req),
      .found_o (lo_found),
      .idx_o   (lo_idx)
   );

   // nesting decision
   logic [1:0]       ins;
   logic             go_hi, go_lo, take;
   logic [SRC_W-1:0] win_idx;
   level_e           win_lvl;

   assign go_hi   = hi_found & ~ins[LVL_HIGH];
   assign go_lo   = lo_found & ~ins[LVL_HIGH] & ~ins[LVL_LOW];
   assign win_idx = go_hi ? hi_idx : lo_idx;
   assign win_lvl = go_hi ? LVL_HIGH : LVL_LOW;
   assign irq_o   = go_hi | go_lo;
   assign take    = ack_i & irq_o;

   always_comb begin
      src_clr = '0;
      if (take) src_clr[win_idx] = 1'b1;
   end

   intc_nest u_nest (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .take_i     (take),
      .take_lvl_i (win_lvl),
      .ret_i      (reti_i),
      .ins_o      (ins)
   );

   // vector latch
   logic [VEC_W-1:0] vec_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         vec_q <= '0;
      end else if (take) begin
         vec_q <= VEC_W'(slot_addr(VEC_BASE, VEC_STRIDE, 32'(win_idx)));
      end
   end

   assign vec_o      = vec_q;
   assign en_reg_o   = en_q;
   assign pri_reg_o  = REG_W'(pri_q);
   assign tmr_flag_o = tmr_flag;
   assign insvc_o    = ins;
endmodule

// File: rtl/two_level_intc_chk.sv
module two_level_intc_chk #(
   parameter int unsigned REG_W      = 8,
   parameter int unsigned VEC_W      = 16,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8,
   parameter int unsigned GLOBAL_BIT = 7
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             ack_i,
   input logic             reti_i,
   input logic             irq_o,
   input logic [VEC_W-1:0] vec_o,
   input logic [REG_W-1:0] en_reg_o,
   input logic [1:0]       insvc_o
);
   // R3
   global_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_reg_o[GLOBAL_BIT] |-> !irq_o);

   // R7
   hi_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      insvc_o[1] |-> !irq_o);

   // R8
   lo_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && irq_o && insvc_o[0]) |=> insvc_o[1]);

   // R5
   vec_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && irq_o) |=> ((32'(vec_o) - VEC_BASE) % VEC_STRIDE) == 0);

   // R14
   vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ack_i && irq_o) |=> $stable(vec_o));

   // R13
   ret_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reti_i && !ack_i && insvc_o[1]) |=> (!insvc_o[1] && insvc_o[0] == $past(insvc_o[0])));
endmodule

bind two_level_intc two_level_intc_chk #(
   .REG_W      (REG_W),
   .VEC_W      (VEC_W),
   .VEC_BASE   (VEC_BASE),
   .VEC_STRIDE (VEC_STRIDE),
   .GLOBAL_BIT (GLOBAL_BIT)
) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .ack_i    (ack_i),
   .reti_i   (reti_i),
   .irq_o    (irq_o),
   .vec_o    (vec_o),
   .en_reg_o (en_reg_o),
   .insvc_o  (insvc_o)
);

// File: tb/two_level_intc_tb_top.sv
`timescale 1ns/10ps
module two_level_intc_tb_top;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        wr_i = 1'b0;
   logic [1:0]  wr_addr_i = '0;
   logic [7:0]  wr_data_i = '0;
   logic [1:0]  ext_i = '0;
   logic [1:0]  tmr_ovf_i = '0;
   logic        ser_rx_i = 1'b0;
   logic        ser_tx_i = 1'b0;
   logic        ack_i = 1'b0;
   logic        reti_i = 1'b0;
   logic        irq_o;
   logic [15:0] vec_o;
   logic [7:0]  en_reg_o;
   logic [7:0]  pri_reg_o;
   logic [1:0]  tmr_flag_o;
   logic [1:0]  insvc_o;

   always #2.5 clk_i = ~clk_i;

   two_level_intc dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .ext_i(ext_i), .tmr_ovf_i(tmr_ovf_i),
      .ser_rx_i(ser_rx_i), .ser_tx_i(ser_tx_i), .ack_i(ack_i), .reti_i(reti_i),
      .irq_o(irq_o), .vec_o(vec_o), .en_reg_o(en_reg_o), .pri_reg_o(pri_reg_o),
      .tmr_flag_o(tmr_flag_o), .insvc_o(insvc_o)
   );

   int errs = 0;
   int checks = 0;
   bit done = 0;

   // reference state
   bit [7:0] m_en, m_pri;
   bit [1:0] m_trig, m_edge, m_prev, m_tf;
   bit       m_hi, m_lo, m_irq;
   int       m_vec, m_win;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit src_pending(int s);
      case (s)
         0: return m_trig[0] ? m_edge[0] : ext_i[0];
         1: return m_tf[0];
         2: return m_trig[1] ? m_edge[1] : ext_i[1];
         3: return m_tf[1];
         default: return ser_rx_i | ser_tx_i;
      endcase
   endfunction

   function automatic bit src_high(int s);
      return (s < 4) ? m_pri[s] : 1'b0;
   endfunction

   function automatic void model_eval();
      m_irq = 0;
      m_win = 0;
      for (int lvl = 1; lvl >= 0 && !m_irq; lvl--) begin
         for (int s = 0; s < 5 && !m_irq; s++) begin
            if (src_pending(s) && m_en[s] && m_en[7] && (int'(src_high(s)) == lvl)) begin
               m_win = s;
               if (lvl == 1) m_irq = !m_hi;
               else          m_irq = !m_hi && !m_lo;
               if (!m_irq) lvl = -1;
            end
         end
      end
   endfunction

   task automatic cyc();
      bit take, ne;
      #0.4;
      model_eval();
      chk("R3", irq_o, m_irq);
      chk("R5", vec_o, m_vec);
      chk("R2", en_reg_o, m_en);
      chk("R4", pri_reg_o, m_pri);
      chk("R12", tmr_flag_o, m_tf);
      chk("R13", insvc_o, {m_hi, m_lo});
      @(posedge clk_i);
      if (!rst_ni) begin
         m_en = 0; m_pri = 0; m_trig = 0; m_edge = 0; m_prev = 0; m_tf = 0;
         m_hi = 0; m_lo = 0; m_vec = 0;
      end else begin
         take = ack_i && m_irq;
         for (int p = 0; p < 2; p++) begin
            ne = ext_i[p] && !m_prev[p];
            m_edge[p] = m_trig[p] && (ne || (m_edge[p] && !(take && m_win == 2*p)));
         end
         m_prev = ext_i;
         for (int k = 0; k < 2; k++) begin
            if (tmr_ovf_i[k])                    m_tf[k] = 1;
            else if (wr_i && wr_addr_i == 3)     m_tf[k] = wr_data_i[k];
            else if (take && m_win == 2*k + 1)   m_tf[k] = 0;
         end
         if (wr_i && wr_addr_i == 0) m_en   = wr_data_i & 8'hBF;
         if (wr_i && wr_addr_i == 1) m_pri  = wr_data_i & 8'h0F;
         if (wr_i && wr_addr_i == 2) m_trig = wr_data_i[1:0];
         if (reti_i) begin
            if (m_hi) m_hi = 0;
            else      m_lo = 0;
         end
         if (take) begin
            if (src_high(m_win)) m_hi = 1;
            else                 m_lo = 1;
            m_vec = 3 + 8 * m_win;
         end
      end
      @(negedge clk_i);
   endtask

   task automatic wr(bit [1:0] a, bit [7:0] d);
      wr_i = 1; wr_addr_i = a; wr_data_i = d;
      cyc();
      wr_i = 0; #0.1;
   endtask

   task automatic do_ack();
      ack_i = 1; cyc(); ack_i = 0; #0.1;
   endtask

   task automatic do_ret();
      reti_i = 1; cyc(); reti_i = 0; #0.1;
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk_i);
      repeat (3) cyc();
      // R1 reset state
      chk("R1", en_reg_o, 8'h00); chk("R1", pri_reg_o, 8'h00);
      chk("R1", irq_o, 0); chk("R1", vec_o, 16'h0000); chk("R1", insvc_o, 2'b00);
      rst_ni = 1;
      cyc();

      // global enable off: flag set but no request (R3)
      wr(0, 8'h1F);
      tmr_ovf_i = 2'b01; cyc(); tmr_ovf_i = 0; #0.1;
      cyc();
      chk("R3", irq_o, 0); chk("R12", tmr_flag_o, 2'b01);
      wr(0, 8'hC2);
      chk("R2", en_reg_o, 8'h82); chk("R2", irq_o, 1);
      do_ack();
      chk("R5", vec_o, 16'h000B); chk("R12", tmr_flag_o, 2'b00); chk("R13", insvc_o, 2'b01);
      do_ret();
      chk("R13", insvc_o, 2'b00);

      // fixed order and level mode
      wr(0, 8'h9F);
      ext_i = 2'b11; ser_rx_i = 1; cyc();
      chk("R6", irq_o, 1);
      do_ack();
      chk("R6", vec_o, 16'h0003); chk("R8", irq_o, 0);
      do_ret();
      chk("R9", irq_o, 1);
      ext_i[0] = 0; cyc();
      do_ack();
      chk("R6", vec_o, 16'h0013);
      do_ret();
      ext_i = 2'b00; cyc();
      do_ack();
      chk("R11", vec_o, 16'h0023);
      do_ret();
      ser_rx_i = 0; ser_tx_i = 1; cyc();
      chk("R11", irq_o, 1);

      // priority register and nesting
      wr(1, 8'hFF);
      chk("R4", pri_reg_o, 8'h0F);
      wr(1, 8'h08);
      do_ack();
      chk("R11", vec_o, 16'h0023); chk("R11", irq_o, 0); chk("R13", insvc_o, 2'b01);
      wr(3, 8'h02);
      chk("R7", irq_o, 1); chk("R12", tmr_flag_o, 2'b10);
      do_ack();
      chk("R7", vec_o, 16'h001B); chk("R13", insvc_o, 2'b11); chk("R7", irq_o, 0);
      wr(3, 8'h02);
      chk("R7", irq_o, 0);
      do_ret();
      chk("R13", insvc_o, 2'b01); chk("R7", irq_o, 1);
      do_ack();
      chk("R7", vec_o, 16'h001B);
      do_ret(); do_ret();
      chk("R13", insvc_o, 2'b00);
      ser_tx_i = 0; wr(1, 8'h00);

      // edge mode on external 1
      wr(2, 8'h02);
      ext_i[1] = 1; cyc();
      chk("R10", irq_o, 1);
      do_ack();
      chk("R10", vec_o, 16'h0013);
      do_ret();
      cyc();
      chk("R10", irq_o, 0);
      ext_i[1] = 0; cyc();
      ext_i[1] = 1; cyc(); cyc();
      chk("R10", irq_o, 1);
      do_ack(); do_ret();

      // acknowledge without request
      cyc();
      do_ack();
      chk("R14", vec_o, 16'h0013); chk("R14", insvc_o, 2'b00);
      ext_i = 0; cyc(); cyc();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule